// File: doc/BRIEF.md
# SMBus timeout and bus-free detector

This block watches the clock and data lines of a two-wire SMBus and reports two bus conditions to the serial engine beside it. The first is a bus-free condition: both lines have stayed high for longer than a set number of periods of a selectable clock-source tick. The second is an SCL-low timeout: the clock line has stayed low for a prescaled number of system clock cycles. Each detection has its own enable. Both lines pass through a two-flop synchroniser and a glitch filter before any counting takes place.

A master that wants to issue a START holds `start_pending` high. The cycle in which the free decision completes also raises a one-cycle `start_go` strobe, so the held-back START can go out at once. The `low_timeout` pulse tells the serial engine to reset itself, which is the same as disabling and re-enabling the interface. The free decision counts ticks, not wall time. It stands in for the protocol's 50 µs rule, and it needs the tick source to be running even when the interface acts only as a slave.

The free detector is a three-state machine:
- `FR_WAIT`: at least one line is low, or the detector is disabled.
- `FR_COUNT`: both lines are high and ticks are being counted.
- `FR_FREE`: the bus is free.

Its transitions are:
- wait-to-count: both lines are high while enabled.
- count-to-count: a tick arrives before the limit.
- count-to-free: the tick that completes the count.
- any-to-wait: a low line or the enable cleared.

The low timer is also a three-state machine:
- `LT_IDLE`: SCL is high or the timer is disabled.
- `LT_RUN`: counting while SCL is low.
- `LT_TRIP`: the timeout has fired, and the timer waits for SCL to rise.

Its transitions are:
- idle-to-run: SCL is low while enabled.
- run-to-run: prescaler and limit counting.
- run-to-trip: the last prescaled period ends, which fires the pulse.
- any-to-idle: SCL goes high or the enable is cleared.

Top module: `smb_bus_watch`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `bus_free`, `start_go` and `low_timeout` are all 0. The internal line state resets to high, but the bus is not counted as free until the full tick count has been seen.
- R2: Each line passes through a two-flop synchroniser and then a filter. The filter changes its output only after the synchronised value has differed from it for FILT_LEN consecutive clock cycles. A pulse shorter than FILT_LEN cycles has no effect on either output.
- R3: With `free_en` high, `bus_free` rises once both filtered lines have stayed high while FREE_TICKS+1 ticks of the selected source are seen. These are counted starting in the cycle after the lines are first seen both high. `bus_free` rises one clock after the last counted tick is sampled.
- R4: A low level on either filtered line (a START included) clears the tick count, and it also clears `bus_free` in the next cycle.
- R5: With `free_en` low, `bus_free` stays 0 and no ticks are counted.
- R6: `start_go` is a single-cycle pulse. It is raised in the same cycle that `bus_free` rises, and only if `start_pending` was high in the cycle the count completed. It is never raised at any other time.
- R7: `src_sel` picks which bit of `src_ticks` is counted. The tick is registered once before use, and ticks on the other bits have no effect.
- R8: With `low_en` high, `low_timeout` pulses for one cycle after filtered SCL has been low for LOW_PRESC*LOW_LIMIT cycles of the counting state. It pulses only once per low period.
- R9: Filtered SCL going high, or `low_en` going low, clears the low timer. No pulse occurs for a low period shorter than the limit.
- R10: Without ticks on the selected source, the bus is never declared free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SMBus clock line level |
| sda_in | input | 1 | Raw SMBus data line level |
| src_ticks | input | NUM_SRC | Candidate clock-source tick strobes |
| src_sel | input | $clog2(NUM_SRC) | Index of the tick source to count |
| free_en | input | 1 | Enables bus-free detection |
| low_en | input | 1 | Enables SCL-low timeout detection |
| start_pending | input | 1 | The master is holding back a START |
| bus_free | output | 1 | The bus is considered free |
| start_go | output | 1 | One-cycle strobe: issue the waiting START now |
| low_timeout | output | 1 | One-cycle SCL-low timeout pulse; resets the serial engine |

## Verification
The assertions assume that `src_ticks`, `src_sel`, the enables and `start_pending` are synchronous to `clk`. They also assume the line inputs may be fully asynchronous, since they are synchronised before use. The bench drives every input on the falling edge, so each input is stable well before the rising edge that samples it. The selection index stays within the range of NUM_SRC. The line glitches the bench injects are shorter than FILT_LEN on purpose, while all real bus transitions are held for longer.

// File: rtl/smbw_pkg.sv
package smbw_pkg;

    typedef enum logic [1:0] {
        FR_WAIT  = 2'd0,
        FR_COUNT = 2'd1,
        FR_FREE  = 2'd2
    } free_state_e;

    typedef enum logic [1:0] {
        LT_IDLE = 2'd0,
        LT_RUN  = 2'd1,
        LT_TRIP = 2'd2
    } low_state_e;

endpackage

// File: rtl/smbw_line_filt.sv
module smbw_line_filt #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);
    localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

    logic          sync1_q;
    logic          sync2_q;
    logic          filt_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
            filt_q  <= 1'b1;
            run_q   <= '0;
        end else begin
            sync1_q <= line_in;
            sync2_q <= sync1_q;
            if (sync2_q == filt_q) begin
                run_q <= '0;
            end else if (run_q == CNT_LAST) begin
                filt_q <= sync2_q;
                run_q  <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign line_out = filt_q;

    AST_FILT_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_q) |-> ($past(sync2_q) == filt_q)); // R2

endmodule

// File: rtl/smbw_tick_sel.sv
module smbw_tick_sel #(
    parameter int NUM_SRC = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         src_ticks,
    input  logic [$clog2(NUM_SRC)-1:0] src_sel,
    output logic                       tick
);
    logic tick_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= 1'b0;
        end else if (int'(src_sel) < NUM_SRC) begin
            tick_q <= src_ticks[src_sel];
        end else begin
            tick_q <= 1'b0;
        end
    end

    assign tick = tick_q;

    AST_TICK_FROM_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |-> ($past(src_ticks) != '0)); // R7

endmodule

// File: rtl/smbw_free_fsm.sv
module smbw_free_fsm
    import smbw_pkg::*;
#(
    parameter int FREE_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic free_en,
    input  logic scl_hi,
    input  logic sda_hi,
    input  logic tick,
    input  logic start_pending,
    output logic bus_free,
    output logic start_go
);
    localparam int CW = $clog2(FREE_TICKS + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(FREE_TICKS);

    free_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          expire;
    logic          both_high;
    logic          start_go_q;

    assign both_high = scl_hi && sda_hi;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        expire  = 1'b0;
        if (!free_en || !both_high) begin
            state_d = FR_WAIT;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                FR_WAIT: begin
                    state_d = FR_COUNT;
                    cnt_d   = '0;
                end
                FR_COUNT: begin
                    if (tick) begin
                        if (cnt_q == CNT_LAST) begin
                            state_d = FR_FREE;
                            cnt_d   = '0;
                            expire  = 1'b1;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                FR_FREE: state_d = FR_FREE;
                default: state_d = FR_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FR_WAIT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_go_q <= 1'b0;
        end else begin
            start_go_q <= expire && start_pending;
        end
    end

    assign bus_free = (state_q == FR_FREE);
    assign start_go = start_go_q;

    AST_FREE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_free) |-> ($past(tick) && $past(both_high))); // R3
    AST_LOW_CLEARS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !both_high |=> !bus_free); // R4
    AST_DISABLED_NOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !free_en |=> !bus_free); // R5
    AST_GO_WITH_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        start_go |-> $rose(bus_free)); // R6
    AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_go |=> !start_go); // R6

endmodule

// File: rtl/smbw_low_timer.sv
module smbw_low_timer
    import smbw_pkg::*;
#(
    parameter int LOW_PRESC = 1000,
    parameter int LOW_LIMIT = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic low_en,
    input  logic scl_hi,
    output logic low_timeout
);
    localparam int PW = (LOW_PRESC > 1) ? $clog2(LOW_PRESC) : 1;
    localparam int LW = (LOW_LIMIT > 1) ? $clog2(LOW_LIMIT) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(LOW_PRESC - 1);
    localparam logic [LW-1:0] LIM_LAST = LW'(LOW_LIMIT - 1);

    low_state_e    state_q, state_d;
    logic [PW-1:0] pre_q, pre_d;
    logic [LW-1:0] lim_q, lim_d;
    logic          fire;
    logic          timeout_q;

    always_comb begin
        state_d = state_q;
        pre_d   = pre_q;
        lim_d   = lim_q;
        fire    = 1'b0;
        if (!low_en || scl_hi) begin
            state_d = LT_IDLE;
            pre_d   = '0;
            lim_d   = '0;
        end else begin
            unique case (state_q)
                LT_IDLE: begin
                    state_d = LT_RUN;
                    pre_d   = '0;
                    lim_d   = '0;
                end
                LT_RUN: begin
                    if (pre_q == PRE_LAST) begin
                        pre_d = '0;
                        if (lim_q == LIM_LAST) begin
                            state_d = LT_TRIP;
                            fire    = 1'b1;
                        end else begin
                            lim_d = lim_q + 1'b1;
                        end
                    end else begin
                        pre_d = pre_q + 1'b1;
                    end
                end
                LT_TRIP: state_d = LT_TRIP;
                default: state_d = LT_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LT_IDLE;
            pre_q   <= '0;
            lim_q   <= '0;
        end else begin
            state_q <= state_d;
            pre_q   <= pre_d;
            lim_q   <= lim_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timeout_q <= 1'b0;
        end else begin
            timeout_q <= fire;
        end
    end

    assign low_timeout = timeout_q;

    AST_TIMEOUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        low_timeout |=> !low_timeout); // R8
    AST_TRIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LT_TRIP) |=> !low_timeout); // R8
    AST_TIMEOUT_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        low_timeout |-> $past(low_en && !scl_hi)); // R9

endmodule

// File: rtl/smb_bus_watch.sv
module smb_bus_watch #(
    parameter int NUM_SRC    = 4,
    parameter int FILT_LEN   = 3,
    parameter int FREE_TICKS = 10,
    parameter int LOW_PRESC  = 1000,
    parameter int LOW_LIMIT  = 25
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_in,
    input  logic                       sda_in,
    input  logic [NUM_SRC-1:0]         src_ticks,
    input  logic [$clog2(NUM_SRC)-1:0] src_sel,
    input  logic                       free_en,
    input  logic                       low_en,
    input  logic                       start_pending,
    output logic                       bus_free,
    output logic                       start_go,
    output logic                       low_timeout
);
    localparam int NUM_LINES = 2;

    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] clean_lines;
    logic                 tick;

    assign raw_lines = {sda_in, scl_in};

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        smbw_line_filt #(.FILT_LEN(FILT_LEN)) i_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .line_in  (raw_lines[g]),
            .line_out (clean_lines[g])
        );
    end

    smbw_tick_sel #(.NUM_SRC(NUM_SRC)) i_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_ticks (src_ticks),
        .src_sel   (src_sel),
        .tick      (tick)
    );

    smbw_free_fsm #(.FREE_TICKS(FREE_TICKS)) i_free (
        .clk           (clk),
        .rst_n         (rst_n),
        .free_en       (free_en),
        .scl_hi        (clean_lines[0]),
        .sda_hi        (clean_lines[1]),
        .tick          (tick),
        .start_pending (start_pending),
        .bus_free      (bus_free),
        .start_go      (start_go)
    );

    smbw_low_timer #(.LOW_PRESC(LOW_PRESC), .LOW_LIMIT(LOW_LIMIT)) i_low (
        .clk         (clk),
        .rst_n       (rst_n),
        .low_en      (low_en),
        .scl_hi      (clean_lines[0]),
        .low_timeout (low_timeout)
    );

    AST_GO_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        start_go |-> $past(start_pending)); // R6
    AST_NO_FREE_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_free) |-> $past(tick)); // R10

endmodule

// File: tb/test_smb_bus_watch.sv
module test_smb_bus_watch;
    localparam int NUM_SRC    = 4;
    localparam int FILT_LEN   = 3;
    localparam int FREE_TICKS = 10;
    localparam int LOW_PRESC  = 4;
    localparam int LOW_LIMIT  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_in = 1'b1, sda_in = 1'b1;
    logic [NUM_SRC-1:0] src_ticks = '0;
    logic [1:0] src_sel = 2'd0;
    logic free_en = 1'b0, low_en = 1'b0, start_pending = 1'b0;
    logic bus_free, start_go, low_timeout;

    int n_checks = 0;
    int n_fail   = 0;
    int go_cnt   = 0;
    int to_cnt   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    smb_bus_watch #(
        .NUM_SRC(NUM_SRC), .FILT_LEN(FILT_LEN), .FREE_TICKS(FREE_TICKS),
        .LOW_PRESC(LOW_PRESC), .LOW_LIMIT(LOW_LIMIT)
    ) i_smb_bus_watch (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .src_ticks(src_ticks), .src_sel(src_sel), .free_en(free_en),
        .low_en(low_en), .start_pending(start_pending),
        .bus_free(bus_free), .start_go(start_go), .low_timeout(low_timeout)
    );

    // behavioural reference model
    logic ms1c, ms2c, mfc, ms1d, ms2d, mfd;
    int   mcc, mcd;
    logic mtick;
    int   mst, mcnt;
    logic mgo;
    int   lst, lpc, llc;
    logic mto;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms1c <= 1; ms2c <= 1; mfc <= 1; mcc <= 0;
            ms1d <= 1; ms2d <= 1; mfd <= 1; mcd <= 0;
            mtick <= 0; mst <= 0; mcnt <= 0; mgo <= 0;
            lst <= 0; lpc <= 0; llc <= 0; mto <= 0;
        end else begin
            ms1c <= scl_in; ms2c <= ms1c;
            ms1d <= sda_in; ms2d <= ms1d;
            if (ms2c == mfc) mcc <= 0;
            else if (mcc == FILT_LEN - 1) begin mfc <= ms2c; mcc <= 0; end
            else mcc <= mcc + 1;
            if (ms2d == mfd) mcd <= 0;
            else if (mcd == FILT_LEN - 1) begin mfd <= ms2d; mcd <= 0; end
            else mcd <= mcd + 1;
            mtick <= src_ticks[src_sel];
            mgo <= 0;
            if (!free_en || !(mfc && mfd)) begin mst <= 0; mcnt <= 0; end
            else if (mst == 0) begin mst <= 1; mcnt <= 0; end
            else if (mst == 1 && mtick) begin
                if (mcnt == FREE_TICKS) begin
                    mst <= 2; mcnt <= 0; mgo <= start_pending;
                end else mcnt <= mcnt + 1;
            end
            mto <= 0;
            if (!low_en || mfc) begin lst <= 0; lpc <= 0; llc <= 0; end
            else if (lst == 0) lst <= 1;
            else if (lst == 1) begin
                if (lpc == LOW_PRESC - 1) begin
                    lpc <= 0;
                    if (llc == LOW_LIMIT - 1) begin lst <= 2; mto <= 1; end
                    else llc <= llc + 1;
                end else lpc <= lpc + 1;
            end
        end
    end

    task automatic check(string req, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    task automatic check_int(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // tick sources: 0 every 2, 1 every 3, 2 every 5, 3 silent; per-cycle compare
    always @(negedge clk) begin
        cyc++;
        src_ticks[0] <= (cyc % 2 == 0);
        src_ticks[1] <= (cyc % 3 == 0);
        src_ticks[2] <= (cyc % 5 == 0);
        src_ticks[3] <= 1'b0;
        if (rst_n && !done) begin
            check("R3", "bus_free vs model", bus_free, (mst == 2));
            check("R6", "start_go vs model", start_go, mgo);
            check("R8", "low_timeout vs model", low_timeout, mto);
            if (start_go) go_cnt++;
            if (low_timeout) to_cnt++;
        end
    end

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        wait_cyc(200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        int n;
        int go0;
        int to0;
        wait_cyc(4);
        check("R1", "bus_free in reset", bus_free, 1'b0);
        check("R1", "low_timeout in reset", low_timeout, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "bus_free after reset", bus_free, 1'b0);
        check("R1", "start_go after reset", start_go, 1'b0);

        // R5: detection disabled
        wait_cyc(100);
        check("R5", "bus_free while disabled", bus_free, 1'b0);

        // R10 / R7: silent source selected
        src_sel = 2'd3; free_en = 1'b1;
        wait_cyc(100);
        check("R10", "bus_free without ticks", bus_free, 1'b0);
        check("R7", "other sources ignored", bus_free, 1'b0);

        // R3 / R6: source 1 with a pending START
        go0 = go_cnt;
        src_sel = 2'd1; start_pending = 1'b1;
        n = 0;
        while (!bus_free && n < 200) begin @(negedge clk); n++; end
        check("R3", "bus_free reached", bus_free, 1'b1);
        check_int("R3", "needs more than FREE_TICKS periods", int'(n >= 3 * FREE_TICKS), 1);
        wait_cyc(3);
        check_int("R6", "one start strobe", go_cnt - go0, 1);

        // R2: short glitches are filtered
        sda_in = 1'b0; @(negedge clk); sda_in = 1'b1;
        wait_cyc(2);
        scl_in = 1'b0; wait_cyc(FILT_LEN - 1); scl_in = 1'b1;
        wait_cyc(10);
        check("R2", "free survives glitches", bus_free, 1'b1);

        // R4: START-like SDA low clears free
        sda_in = 1'b0; wait_cyc(8);
        check("R4", "bus_free cleared by low line", bus_free, 1'b0);
        sda_in = 1'b1;

        // R6: no strobe without pending; R7 faster source
        go0 = go_cnt; start_pending = 1'b0; src_sel = 2'd0;
        n = 0;
        while (!bus_free && n < 200) begin @(negedge clk); n++; end
        check("R7", "free with source 0", bus_free, 1'b1);
        check_int("R6", "no strobe without pending", go_cnt - go0, 0);

        // R8: long SCL low fires once
        to0 = to_cnt; low_en = 1'b1; scl_in = 1'b0;
        wait_cyc(LOW_PRESC * LOW_LIMIT + 40);
        check_int("R8", "single timeout per low period", to_cnt - to0, 1);
        check("R4", "free cleared by scl low", bus_free, 1'b0);
        scl_in = 1'b1; wait_cyc(10);

        // R9: short low periods and disable
        to0 = to_cnt;
        for (int k = 0; k < 3; k++) begin
            scl_in = 1'b0; wait_cyc(LOW_PRESC * LOW_LIMIT - 4);
            scl_in = 1'b1; wait_cyc(10);
        end
        check_int("R9", "no timeout on short lows", to_cnt - to0, 0);
        low_en = 1'b0; scl_in = 1'b0;
        wait_cyc(LOW_PRESC * LOW_LIMIT + 40);
        check_int("R9", "no timeout while disabled", to_cnt - to0, 0);
        scl_in = 1'b1;
        wait_cyc(20);
        finish_run();
    end

endmodule